// File: doc/BRIEF.md
# Root Port Status and Control Register

This block holds the 32-bit status and control word of one host-controller root port. Software reads the whole word at any time and writes a full word through a single-cycle write strobe. Each field obeys its own access rule: some mirror live port inputs and ignore writes, some are plain storage, one starts an action when a 1 is written, several are change flags cleared by writing 1, and one bit is a strobe that gates the update of another field. Because of this mix, software can take the value it read, mask it down to the read-only and plain-storage fields, add the single bit it wants to act on, and write it back without disturbing anything else.

The block also runs the port reset sequence. A reset runs for a parameterised number of cycles and then enables the port and raises a completion flag. It latches the change flags raised by the connect and over-current inputs. Several ports are built by instantiating the block once per port. The register bus has no back-pressure: `wr_en` is accepted on every cycle it is high, and `rd_data` is always valid.

Two resets are present. `rst_n` is the asynchronous power-on reset and clears every bit. `ctl_rst` is a synchronous controller reset and clears everything except the sampled input status.

Top module: `root_port_sc`

## Requirements
- R1: Bits 0 (connect), 3 (over-current), 13:10 (speed code) and 30 (removable) show `hw_connect`, `hw_overcur`, `hw_speed` and `hw_removable` as they were sampled at the previous clock edge. Writes to these bits are ignored.
- R2: Bit 9 (power), bits 15:14 (indicator) and bits 27:25 (wake enables) take the written value on every write, whether that value is 0 or 1.
- R3: Bits 8:5 (link state) load `wr_data[8:5]` only on a write with `wr_data[16]` = 1. Any other cycle leaves them unchanged. Bit 16 always reads 0.
- R4: Bits 2, 16, 19, 22, 23, 24, 28, 29 and 31 always read 0.
- R5: A write with bit 4 = 1 while no reset is running sets bit 4 for exactly RST_CYCLES cycles and clears bit 1 (enabled). While the reset runs, bits 1 and 4 are never both 1. Writing 0 to bit 4 has no effect, and writing 1 to bit 4 during a reset does not restart it.
- R6: At the edge where bit 4 clears on its own, bit 1 and bit 21 (reset-change) are set.
- R7: Writing 1 to bit 1, 17, 18, 20 or 21 clears that bit. Writing 0 to any of them has no effect.
- R8: A change of `hw_connect` sets bit 17. A rising edge of `hw_overcur` sets bit 20. A disconnect while bit 1 is set clears bit 1 and sets bit 18.
- R9: When a write clears a change flag at the same edge that a hardware event sets it, the flag ends up set.
- R10: `ctl_rst` clears every bit except 0, 3, 13:10 and 30. `rst_n` low clears all bits.
- R11: Writing back (read value AND 0x40003C09) OR (read value AND 0x0E00C3E0) leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ctl_rst | input | 1 | Synchronous controller reset |
| hw_connect | input | 1 | Device attached |
| hw_speed | input | 4 | Speed code of the attached device |
| hw_overcur | input | 1 | Over-current condition |
| hw_removable | input | 1 | Device is removable |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |

## Verification
Every result lands one clock edge after its cause. Input status, change flags, write effects and the start of a reset are all visible right after the edge that samples the stimulus. The reset bit then reads 1 for RST_CYCLES edges, and the enable and completion flags appear at the edge where it drops. The bench drives inputs 2 ns after the rising edge. It reads directed results right after the edge that consumed the stimulus, and it compares the full word with a behavioural model at every falling edge, so no value is read at the edge that changes it.

// File: rtl/rpsc_pkg.sv
package rpsc_pkg;
  localparam int REG_W     = 32;
  localparam int SPD_W     = 4;
  localparam int LS_W      = 4;
  localparam int IND_W     = 2;
  localparam int WAKE_W    = 3;
  localparam int NFLAG     = 4;

  localparam int B_CONN    = 0;
  localparam int B_ENA     = 1;
  localparam int B_OVC     = 3;
  localparam int B_PRST    = 4;
  localparam int B_LS      = 5;
  localparam int B_PWR     = 9;
  localparam int B_SPD     = 10;
  localparam int B_IND     = 14;
  localparam int B_LSSTB   = 16;
  localparam int B_CONNCHG = 17;
  localparam int B_ENACHG  = 18;
  localparam int B_OVCCHG  = 20;
  localparam int B_RSTCHG  = 21;
  localparam int B_WAKE    = 25;
  localparam int B_REMOV   = 30;

  // change-flag slots inside the flag bank
  localparam int F_CONN = 0;
  localparam int F_ENA  = 1;
  localparam int F_OVC  = 2;
  localparam int F_RST  = 3;

  localparam logic [REG_W-1:0] ZERO_MASK = 32'hB1C9_0004;

  typedef struct packed {
    logic             conn;
    logic             ovc;
    logic             remov;
    logic [SPD_W-1:0] spd;
  } sense_t;
endpackage

// File: rtl/rpsc_sense.sv
module rpsc_sense
  import rpsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_connect,
  input  logic [SPD_W-1:0] hw_speed,
  input  logic             hw_overcur,
  input  logic             hw_removable,
  output sense_t           sense_q,
  output logic             conn_chg,
  output logic             ovc_rise,
  output logic             disc
);
  // Input status is sampled every cycle; only the power-on reset clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
    end else begin
      sense_q.conn  <= hw_connect;
      sense_q.ovc   <= hw_overcur;
      sense_q.remov <= hw_removable;
      sense_q.spd   <= hw_speed;
    end
  end

  assign conn_chg = hw_connect ^ sense_q.conn;
  assign ovc_rise = hw_overcur & ~sense_q.ovc;
  assign disc     = sense_q.conn & ~hw_connect;
endmodule

// File: rtl/rpsc_reset_seq.sv
module rpsc_reset_seq #(
  parameter int RST_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_rst,
  input  logic start_req,
  input  logic ena_clr,
  output logic in_reset,
  output logic enabled,
  output logic done
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign done = in_reset && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_reset <= 1'b0;
      enabled  <= 1'b0;
      cnt_q    <= '0;
    end else if (ctl_rst) begin
      in_reset <= 1'b0;
      enabled  <= 1'b0;
      cnt_q    <= '0;
    end else if (in_reset) begin
      if (done) begin
        in_reset <= 1'b0;
        enabled  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (start_req) begin
      in_reset <= 1'b1;
      enabled  <= 1'b0;
      cnt_q    <= CW'(RST_CYCLES - 1);
    end else if (ena_clr) begin
      enabled <= 1'b0;
    end
  end
endmodule

// File: rtl/rpsc_flags.sv
module rpsc_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_rst,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_clr,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q[i] <= 1'b0;
      else if (ctl_rst)   flag_q[i] <= 1'b0;
      else if (hw_set[i]) flag_q[i] <= 1'b1;
      else if (sw_clr[i]) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/root_port_sc.sv
module root_port_sc
  import rpsc_pkg::*;
#(
  parameter int RST_CYCLES = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_rst,
  input  logic             hw_connect,
  input  logic [3:0]       hw_speed,
  input  logic             hw_overcur,
  input  logic             hw_removable,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data
);
  sense_t            sense_q;
  logic              conn_chg, ovc_rise, disc;
  logic              in_reset, enabled, rst_done;
  logic [NFLAG-1:0]  flag_set, flag_clr, flag_q;
  logic [LS_W-1:0]   ls_q;
  logic              pwr_q;
  logic [IND_W-1:0]  ind_q;
  logic [WAKE_W-1:0] wake_q;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^wr_data;

  rpsc_sense u_sense (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_connect   (hw_connect),
    .hw_speed     (hw_speed),
    .hw_overcur   (hw_overcur),
    .hw_removable (hw_removable),
    .sense_q      (sense_q),
    .conn_chg     (conn_chg),
    .ovc_rise     (ovc_rise),
    .disc         (disc)
  );

  rpsc_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_rst   (ctl_rst),
    .start_req (wr_en & wr_data[B_PRST]),
    .ena_clr   ((wr_en & wr_data[B_ENA]) | disc),
    .in_reset  (in_reset),
    .enabled   (enabled),
    .done      (rst_done)
  );

  always_comb begin
    flag_set        = '0;
    flag_set[F_CONN] = conn_chg;
    flag_set[F_ENA]  = enabled & disc;
    flag_set[F_OVC]  = ovc_rise;
    flag_set[F_RST]  = rst_done;
    flag_clr        = '0;
    flag_clr[F_CONN] = wr_en & wr_data[B_CONNCHG];
    flag_clr[F_ENA]  = wr_en & wr_data[B_ENACHG];
    flag_clr[F_OVC]  = wr_en & wr_data[B_OVCCHG];
    flag_clr[F_RST]  = wr_en & wr_data[B_RSTCHG];
  end

  rpsc_flags #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_rst (ctl_rst),
    .hw_set  (flag_set),
    .sw_clr  (flag_clr),
    .flag_q  (flag_q)
  );

  // plain storage fields; link state gated by its strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_q   <= '0;
      pwr_q  <= 1'b0;
      ind_q  <= '0;
      wake_q <= '0;
    end else if (ctl_rst) begin
      ls_q   <= '0;
      pwr_q  <= 1'b0;
      ind_q  <= '0;
      wake_q <= '0;
    end else if (wr_en) begin
      pwr_q  <= wr_data[B_PWR];
      ind_q  <= wr_data[B_IND +: IND_W];
      wake_q <= wr_data[B_WAKE +: WAKE_W];
      if (wr_data[B_LSSTB]) ls_q <= wr_data[B_LS +: LS_W];
    end
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[B_CONN]            = sense_q.conn;
    rd_data[B_ENA]             = enabled;
    rd_data[B_OVC]             = sense_q.ovc;
    rd_data[B_PRST]            = in_reset;
    rd_data[B_LS +: LS_W]      = ls_q;
    rd_data[B_PWR]             = pwr_q;
    rd_data[B_SPD +: SPD_W]    = sense_q.spd;
    rd_data[B_IND +: IND_W]    = ind_q;
    rd_data[B_CONNCHG]         = flag_q[F_CONN];
    rd_data[B_ENACHG]          = flag_q[F_ENA];
    rd_data[B_OVCCHG]          = flag_q[F_OVC];
    rd_data[B_RSTCHG]          = flag_q[F_RST];
    rd_data[B_WAKE +: WAKE_W]  = wake_q;
    rd_data[B_REMOV]           = sense_q.remov;
  end
endmodule

// File: rtl/root_port_sc_chk.sv
module root_port_sc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_rst,
  input logic        hw_connect,
  input logic        ls_strobe_wr,
  input logic [31:0] rd_data
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_conn_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> rd_data[0] == $past(hw_connect));

  assert_ls_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(ls_strobe_wr) && !$past(ctl_rst)) |-> rd_data[8:5] == $past(rd_data[8:5]));

  assert_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 32'hB1C9_0004) == 32'h0);

  assert_rst_excl_ena_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data[4] && rd_data[1]));

  assert_rst_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(rd_data[4]) && !rd_data[4] && !$past(ctl_rst)) |-> (rd_data[1] && rd_data[21]));

  assert_conn_chg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rd_data[0] != $past(rd_data[0]) && !$past(ctl_rst)) |-> rd_data[17]);

  assert_ovc_chg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rd_data[3] && !$past(rd_data[3]) && !$past(ctl_rst)) |-> rd_data[20]);
endmodule

bind root_port_sc root_port_sc_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctl_rst      (ctl_rst),
  .hw_connect   (hw_connect),
  .ls_strobe_wr (wr_en & wr_data[16]),
  .rd_data      (rd_data)
);

// File: tb/root_port_sc_test.sv
`timescale 1ns/1ps
module root_port_sc_test;
  localparam int RST = 6;
  localparam logic [31:0] RO_M = 32'h4000_3C09;
  localparam logic [31:0] RW_M = 32'h0E00_C3E0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_rst = 1'b0;
  logic        hw_connect = 1'b0;
  logic [3:0]  hw_speed = 4'd0;
  logic        hw_overcur = 1'b0;
  logic        hw_removable = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  root_port_sc #(.RST_CYCLES(RST)) uut (
    .clk(clk), .rst_n(rst_n), .ctl_rst(ctl_rst), .hw_connect(hw_connect),
    .hw_speed(hw_speed), .hw_overcur(hw_overcur), .hw_removable(hw_removable),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  // ---------------- behavioural reference model ----------------
  bit m_conn, m_ovc, m_rem, m_ena, m_rst, m_pwr;
  bit m_cchg, m_echg, m_ochg, m_rchg;
  int m_cnt, m_ls, m_spd, m_ind, m_wake;

  function automatic logic [31:0] model_word();
    logic [31:0] v = 0;
    v[0] = m_conn; v[1] = m_ena; v[3] = m_ovc; v[4] = m_rst;
    v[8:5] = 4'(m_ls); v[9] = m_pwr; v[13:10] = 4'(m_spd); v[15:14] = 2'(m_ind);
    v[17] = m_cchg; v[18] = m_echg; v[20] = m_ochg; v[21] = m_rchg;
    v[27:25] = 3'(m_wake); v[30] = m_rem;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_conn = 0; m_ovc = 0; m_rem = 0; m_ena = 0; m_rst = 0; m_pwr = 0;
      m_cchg = 0; m_echg = 0; m_ochg = 0; m_rchg = 0;
      m_cnt = 0; m_ls = 0; m_spd = 0; m_ind = 0; m_wake = 0;
    end else begin
      bit cev, oev, dis, eev, fin;
      cev = (hw_connect != m_conn);
      oev = hw_overcur && !m_ovc;
      dis = m_conn && !hw_connect;
      eev = m_ena && dis;
      fin = m_rst && (m_cnt == 0);
      if (ctl_rst) begin
        m_ena = 0; m_rst = 0; m_cnt = 0; m_pwr = 0; m_ls = 0; m_ind = 0; m_wake = 0;
        m_cchg = 0; m_echg = 0; m_ochg = 0; m_rchg = 0;
      end else begin
        if (m_rst) begin
          if (fin) begin m_rst = 0; m_ena = 1; end
          else m_cnt = m_cnt - 1;
        end else if (wr_en && wr_data[4]) begin
          m_rst = 1; m_cnt = RST - 1; m_ena = 0;
        end else if ((wr_en && wr_data[1]) || dis) m_ena = 0;
        if (cev) m_cchg = 1; else if (wr_en && wr_data[17]) m_cchg = 0;
        if (eev) m_echg = 1; else if (wr_en && wr_data[18]) m_echg = 0;
        if (oev) m_ochg = 1; else if (wr_en && wr_data[20]) m_ochg = 0;
        if (fin) m_rchg = 1; else if (wr_en && wr_data[21]) m_rchg = 0;
        if (wr_en) begin
          m_pwr = wr_data[9]; m_ind = int'(wr_data[15:14]); m_wake = int'(wr_data[27:25]);
          if (wr_data[16]) m_ls = int'(wr_data[8:5]);
        end
      end
      m_conn = hw_connect; m_ovc = hw_overcur; m_rem = hw_removable; m_spd = int'(hw_speed);
    end
  end

  function automatic string req_of(logic [31:0] d);
    if (d & RO_M)               return "R1";
    if (d & 32'h0E00_C200)      return "R2";
    if (d & 32'h0000_01E0)      return "R3";
    if (d & 32'hB1C9_0004)      return "R4";
    if (d & 32'h0000_0010)      return "R5";
    if (d & 32'h0020_0002)      return "R6";
    return "R8";
  endfunction

  always @(negedge clk) begin
    if (!done_flag) begin
      logic [31:0] e;
      e = model_word();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s model compare t=%0t: actual %h expected %h",
                 req_of(rd_data ^ e), $time, rd_data, e);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic chk(input logic [31:0] mask, input logic [31:0] exp, input string tag);
    checks++;
    if ((rd_data & mask) !== (exp & mask)) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, rd_data & mask, exp & mask);
    end
  endtask

  function automatic logic [31:0] neutral(input logic [31:0] v);
    return (v & RO_M) | (v & RW_M);
  endfunction

  initial begin : watchdog
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] n;
    repeat (3) cyc();
    chk(32'hFFFF_FFFF, 32'h0, "R10 power-on reset value");
    rst_n = 1'b1;
    cyc();

    hw_connect = 1; hw_speed = 4'd3; hw_removable = 1;
    cyc();
    chk(32'hFFFF_FFFF, 32'h4002_0C01, "R1/R8 inputs sampled, connect change");

    wr(32'h0);
    chk(32'hFFFF_FFFF, 32'h4002_0C01, "R1/R7 zero write ignored");

    wr(32'h0E00_C2A0);
    chk(32'hFFFF_FFFF, 32'h4E02_CE01, "R2/R3 storage written, link state held");

    wr(32'h0E01_C2A0);
    chk(32'hFFFF_FFFF, 32'h4E02_CEA1, "R3/R4 strobe loads link state, strobe reads 0");

    n = neutral(rd_data);
    wr(n);
    chk(32'hFFFF_FFFF, 32'h4E02_CEA1, "R11 neutral write-back");

    wr(n | 32'h0002_0000);
    chk(32'hFFFF_FFFF, 32'h4E00_CEA1, "R7 clear connect change");

    wr(n | 32'h10);
    chk(32'hFFFF_FFFF, 32'h4E00_CEB1, "R5 reset started");
    for (int k = 1; k < RST; k++) begin
      if (k == 2) begin wr_en = 1; wr_data = n | 32'h10; end
      cyc();
      wr_en = 0; wr_data = '0;
      chk(32'h0000_0012, 32'h10, "R5 reset held, port disabled");
    end
    cyc();
    chk(32'hFFFF_FFFF, 32'h4E20_CEA3, "R6 reset completes");

    wr(n | 32'h2);
    chk(32'hFFFF_FFFF, 32'h4E20_CEA1, "R7 clear enable");

    wr(n | 32'h10);
    repeat (RST) cyc();
    chk(32'hFFFF_FFFF, 32'h4E20_CEA3, "R6 second reset completes");

    hw_connect = 0;
    wr(n | 32'h0002_0000);
    chk(32'hFFFF_FFFF, 32'h4E26_CEA0, "R9/R8 set beats clear, disconnect disables");

    wr(neutral(rd_data));
    chk(32'hFFFF_FFFF, 32'h4E26_CEA0, "R7 zero write keeps flags");
    wr(neutral(rd_data) | 32'h0026_0000);
    chk(32'hFFFF_FFFF, 32'h4E00_CEA0, "R7 clear change flags");

    hw_overcur = 1;
    cyc();
    chk(32'hFFFF_FFFF, 32'h4E10_CEA8, "R8 over-current rise");
    wr(neutral(rd_data) | 32'h0010_0000);
    chk(32'hFFFF_FFFF, 32'h4E00_CEA8, "R7 over-current flag cleared, level held");

    hw_connect = 1;
    cyc();
    ctl_rst = 1;
    cyc();
    ctl_rst = 0;
    chk(32'hFFFF_FFFF, 32'h4000_0C09, "R10 controller reset keeps input status");

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(7) == 0) hw_connect = ~hw_connect;
      if ($urandom_range(7) == 0) hw_overcur = ~hw_overcur;
      hw_speed = 4'($urandom_range(15));
      hw_removable = 1'($urandom_range(1));
      wr_en = ($urandom_range(2) == 0);
      wr_data = $urandom;
      ctl_rst = ($urandom_range(39) == 0);
      cyc();
    end
    wr_en = 0; ctl_rst = 0;
    cyc();

    rst_n = 0;
    #1;
    chk(32'hFFFF_FFFF, 32'h0, "R10 async reset clears all");
    cyc();
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule